// File: doc/BRIEF.md
# Sized I/O Access Decoder

This block sits between a CPU data port and a group of memory-mapped peripheral registers. It occupies a 32 KB window at the top of a 24-bit address space. It takes one access of byte, word or long size and walks it one byte lane per clock, lowest address first. Each lane is classified as belonging to a mapped register, to void space, or to bus-error space. Lanes that hit a mapped register drive a byte-wide lane bus toward the register store, which is external. The decoder collects read bytes into a right-aligned, big-endian result. At the end it reports completion and, when the whole access landed in error space, a bus error.

Mapped registers may span several bytes. A register gets a select pulse only on the first lane of an access that enters it, so a multi-byte register sees one handler event per access. Base addresses inside the sound-chip block are folded onto its four real byte addresses before decoding. Two configuration inputs reshape the map: one removes the block-transfer unit, and one turns most of the clock-chip range into silent void space.

The fixed register map, by register index: 0 = 0xFF8001 (1 byte), 1 = 0xFF8205 (1 byte), 2 = 0xFF8800–0xFF8801, 3 = 0xFF8802–0xFF8803, 4 = 0xFF8A00–0xFF8A3F, 5 = 0xFFFA00–0xFFFA3F, 6 = 0xFFFC20–0xFFFC3F. Every other window byte is bus-error space unless a configuration input makes it void.

Top module: `io_sized_decoder`

## Requirements
- R1: Only address bits 23:0 matter. An accepted request whose 24-bit base is below 0xFF8000 processes no lanes. In the next cycle it pulses done and bus_err together, with rdata all ones.
- R2: The size encoding is 00 = byte (1 lane), 01 = word (2 lanes) and 10 = long (4 lanes). Lane k uses address base+k and is presented in the k-th cycle after the accepting edge. done is high for exactly one cycle, the cycle after the last lane.
- R3: bus_err is asserted with done only when every lane of the access is an error lane. A byte read at 0xFF8204 faults, but a word read at 0xFF8204 does not, because it reaches register 1.
- R4: An error lane returns 0xFF in its read byte and never asserts lane_we.
- R5: reg_sel is one-hot or zero. Bit i pulses in a lane that hits register i only when the previous lane of the same access did not hit register i.
- R6: A 24-bit base in 0xFF8800–0xFF88FF is replaced by 0xFF8800 plus its low two bits before lanes are generated. The lanes that follow are not folded again.
- R7: With cfg_void_clk high, addresses 0xFFFC21–0xFFFC3F are void. They read 0xFF, never assert lane_we and never count toward a bus error. 0xFFFC20 stays mapped.
- R8: The block rejects a word with base above 0xFFFFFE, a long with base above 0xFFFFFC, and size 11. A rejected access processes no lanes and pulses done in the next cycle with bus_err low and rdata all ones.
- R9: With cfg_blk_err high, 0xFF8A00–0xFF8A3F is bus-error space. With it low, that range is register 4.
- R10: Read data holds lane bytes big-endian and right-aligned: lane 0 is the most significant byte of the access's width, and the upper unused bytes are zero. On writes, lane k carries byte (n-1-k) of wdata, where n is the lane count.
- R11: A request presented while an access is in progress is ignored.
- R12: A mapped lane puts its address on lane_addr. On a write it asserts lane_we with the byte on lane_wdata; on a read it takes lane_rdata in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, sampled while idle |
| addr | input | 32 | Byte address; bits 23:0 used |
| size | input | 2 | 00 byte, 01 word, 10 long |
| wr | input | 1 | 1 = write, 0 = read |
| wdata | input | 32 | Write data, right-aligned |
| cfg_blk_err | input | 1 | Turn block-transfer range into error space |
| cfg_void_clk | input | 1 | Turn clock-chip upper range into void space |
| lane_rdata | input | 8 | Byte from register store at lane_addr |
| reg_sel | output | 7 | Per-register select pulse |
| lane_addr | output | 24 | Byte address of current lane |
| lane_we | output | 1 | Byte write strobe for mapped lane |
| lane_wdata | output | 8 | Byte to write in current lane |
| rdata | output | 32 | Assembled read data, valid with done |
| done | output | 1 | Access complete pulse |
| bus_err | output | 1 | Bus error response, with done |

## Verification
The bound checker enforces the following on every cycle:
- reg_sel is never more than one-hot, and neither it nor lane_we appears outside an active access;
- bus_err never appears without done, and done follows the end of every lane sequence;
- an out-of-window or reserved-size request produces its response on the next edge.

Other behaviour depends on the map contents and only the bench scenarios show it:
- which lanes are error, void or mapped;
- fault-only-when-all-lanes-fault against the map;
- alias folding;
- the single selection of multi-byte registers;
- the byte order of read and write data.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;

   localparam int AW   = 24;
   localparam int NREG = 7;

   typedef enum logic [1:0] {
      LC_REG  = 2'd0,
      LC_VOID = 2'd1,
      LC_ERR  = 2'd2
   } lane_cls_t;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_WORD = 2'b01,
      SZ_LONG = 2'b10,
      SZ_RSVD = 2'b11
   } acc_size_t;

   localparam logic [AW-1:0] WIN_LO   = 24'hFF8000;
   localparam logic [AW-1:0] ALIAS_LO = 24'hFF8800;
   localparam logic [AW-1:0] ALIAS_HI = 24'hFF88FF;
   localparam int            ALIAS_KEEP = 2;
   localparam logic [AW-1:0] VOID_LO  = 24'hFFFC21;
   localparam logic [AW-1:0] VOID_HI  = 24'hFFFC3F;
   localparam int            BLK_REG  = 4;

   localparam logic [AW-1:0] REG_LO [NREG] = '{
      24'hFF8001, 24'hFF8205, 24'hFF8800, 24'hFF8802,
      24'hFF8A00, 24'hFFFA00, 24'hFFFC20 };
   localparam int REG_LEN [NREG] = '{ 1, 1, 2, 2, 64, 64, 32 };

endpackage

// File: rtl/io_region_map.sv
module io_region_map
   import io_dec_pkg::*;
#(
   parameter int MAP_AW = AW,
   parameter int MAP_N  = NREG,
   parameter int ID_W   = $clog2(NREG + 3)
) (
   input  logic [MAP_AW-1:0] addr,
   input  logic              cfg_blk_err,
   input  logic              cfg_void_clk,
   output lane_cls_t         cls,
   output logic [ID_W-1:0]   id
);

   if (MAP_N != NREG) begin : g_bad_n
      $error("io_region_map: MAP_N must match the package map");
   end
   if (MAP_AW != AW) begin : g_bad_aw
      $error("io_region_map: MAP_AW must match the package width");
   end

   logic [MAP_N-1:0] hit;
   logic [MAP_AW:0]  addr_x;

   assign addr_x = {1'b0, addr};

   for (genvar i = 0; i < MAP_N; i++) begin : g_cmp
      localparam logic [MAP_AW:0] LO = {1'b0, REG_LO[i]};
      localparam logic [MAP_AW:0] HI = LO + (MAP_AW+1)'(REG_LEN[i]);
      assign hit[i] = (addr_x >= LO) && (addr_x < HI);
   end

   always_comb begin
      cls = LC_ERR;
      id  = ID_W'(MAP_N + 1) + ID_W'(addr[0]);
      if (cfg_void_clk && (addr >= VOID_LO) && (addr <= VOID_HI)) begin
         cls = LC_VOID;
         id  = ID_W'(MAP_N);
      end else if (cfg_blk_err && hit[BLK_REG]) begin
         cls = LC_ERR;
      end else begin
         for (int i = MAP_N - 1; i >= 0; i--) begin
            if (hit[i]) begin
               cls = LC_REG;
               id  = ID_W'(i);
            end
         end
      end
   end

endmodule

// File: rtl/io_lane_seq.sv
module io_lane_seq #(
   parameter int SEQ_AW    = 24,
   parameter int LANE_W    = 8,
   parameter int MAX_LANES = 4,
   localparam int DW = LANE_W * MAX_LANES,
   localparam int CW = $clog2(MAX_LANES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [SEQ_AW-1:0] base_in,
   input  logic [CW-1:0]     nlanes_in,
   input  logic              wr_in,
   input  logic [DW-1:0]     wdata_in,
   output logic              busy,
   output logic [SEQ_AW-1:0] lane_addr,
   output logic              lane_first,
   output logic              lane_last,
   output logic              lane_wr,
   output logic [LANE_W-1:0] lane_wdata
);

   typedef enum logic { S_IDLE, S_RUN } seq_st_t;

   seq_st_t           st;
   logic [SEQ_AW-1:0] base_q;
   logic [CW-1:0]     idx_q;
   logic [CW-1:0]     n_q;
   logic [DW-1:0]     wsh_q;

   assign busy       = (st == S_RUN);
   assign lane_addr  = base_q + SEQ_AW'(idx_q);
   assign lane_first = (idx_q == '0);
   assign lane_last  = (idx_q == (n_q - CW'(1)));
   assign lane_wdata = wsh_q[DW-1 -: LANE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         base_q  <= '0;
         idx_q   <= '0;
         n_q     <= CW'(1);
         lane_wr <= 1'b0;
         wsh_q   <= '0;
      end else if (st == S_IDLE) begin
         if (go) begin
            st      <= S_RUN;
            base_q  <= base_in;
            idx_q   <= '0;
            n_q     <= nlanes_in;
            lane_wr <= wr_in;
            wsh_q   <= wdata_in << (LANE_W * (MAX_LANES - int'(nlanes_in)));
         end
      end else begin
         idx_q <= idx_q + CW'(1);
         wsh_q <= wsh_q << LANE_W;
         if (lane_last) begin
            st <= S_IDLE;
         end
      end
   end

endmodule

// File: rtl/io_lane_acc.sv
module io_lane_acc
   import io_dec_pkg::*;
#(
   parameter int ID_W      = 4,
   parameter int LANE_W    = 8,
   parameter int MAX_LANES = 4,
   localparam int DW = LANE_W * MAX_LANES,
   localparam int CW = $clog2(MAX_LANES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CW-1:0]     nlanes_in,
   input  logic              rej,
   input  logic              rej_fault,
   input  logic              lane_act,
   input  logic              lane_first,
   input  logic              lane_last,
   input  lane_cls_t         cls,
   input  logic [ID_W-1:0]   id,
   input  logic [LANE_W-1:0] lane_byte,
   output logic              fresh,
   output logic [DW-1:0]     rdata,
   output logic              done,
   output logic              bus_err
);

   logic [ID_W-1:0] prev_id;
   logic [CW-1:0]   ecnt_q, ecnt_nx, n_q;
   logic [DW-1:0]   sh_q, sh_nx;

   assign fresh = lane_first || (id != prev_id);

   always_comb begin
      ecnt_nx = ecnt_q;
      if (lane_act && (cls == LC_ERR) && fresh) begin
         ecnt_nx = ecnt_q + CW'(1);
      end
      sh_nx = {sh_q[DW-LANE_W-1:0], lane_byte};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_id <= '0;
         ecnt_q  <= '0;
         n_q     <= '0;
         sh_q    <= '0;
         rdata   <= '0;
         done    <= 1'b0;
         bus_err <= 1'b0;
      end else begin
         done    <= 1'b0;
         bus_err <= 1'b0;
         if (start) begin
            ecnt_q <= '0;
            sh_q   <= '0;
            n_q    <= nlanes_in;
         end
         if (rej) begin
            done    <= 1'b1;
            bus_err <= rej_fault;
            rdata   <= '1;
         end
         if (lane_act) begin
            ecnt_q  <= ecnt_nx;
            sh_q    <= sh_nx;
            prev_id <= id;
            if (lane_last) begin
               done    <= 1'b1;
               bus_err <= (ecnt_nx == n_q);
               rdata   <= sh_nx;
            end
         end
      end
   end

endmodule

// File: rtl/io_sized_decoder.sv
module io_sized_decoder
   import io_dec_pkg::*;
#(
   parameter int IN_AW     = 32,
   parameter int LANE_W    = 8,
   parameter int MAX_LANES = 4,
   localparam int DATA_W = LANE_W * MAX_LANES,
   localparam int CW     = $clog2(MAX_LANES + 1),
   localparam int ID_W   = $clog2(NREG + 3)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [IN_AW-1:0]  addr,
   input  logic [1:0]        size,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              cfg_blk_err,
   input  logic              cfg_void_clk,
   input  logic [LANE_W-1:0] lane_rdata,
   output logic [NREG-1:0]   reg_sel,
   output logic [AW-1:0]     lane_addr,
   output logic              lane_we,
   output logic [LANE_W-1:0] lane_wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              done,
   output logic              bus_err
);

   if (IN_AW < AW) begin : g_bad_in_aw
      $error("io_sized_decoder: IN_AW must cover the 24-bit space");
   end
   if (LANE_W != 8) begin : g_bad_lane
      $error("io_sized_decoder: lanes are byte wide");
   end
   if (MAX_LANES != 4) begin : g_bad_lanes
      $error("io_sized_decoder: long accesses need four lanes");
   end

   logic [AW-1:0]     a24, base_fold;
   logic [CW-1:0]     nl;
   logic              below, illegal, accept, go, rej;
   logic              busy, first, last, wr_q, fresh;
   lane_cls_t         cls;
   logic [ID_W-1:0]   id;
   logic [LANE_W-1:0] lane_byte;

   assign a24 = addr[AW-1:0];

   if (IN_AW > AW) begin : g_hi
      logic addr_unused_hi;
      assign addr_unused_hi = ^addr[IN_AW-1:AW];
   end

   always_comb begin
      case (acc_size_t'(size))
         SZ_BYTE: nl = CW'(1);
         SZ_WORD: nl = CW'(2);
         SZ_LONG: nl = CW'(4);
         default: nl = '0;
      endcase
   end

   assign below   = (a24 < WIN_LO);
   assign illegal = (nl == '0) ||
                    (({1'b0, a24} + (AW+1)'(nl)) > ((AW+1)'(1) << AW));
   assign base_fold = ((a24 >= ALIAS_LO) && (a24 <= ALIAS_HI)) ?
                      {ALIAS_LO[AW-1:ALIAS_KEEP], a24[ALIAS_KEEP-1:0]} : a24;

   assign accept = req && !busy;
   assign go     = accept && !below && !illegal;
   assign rej    = accept && (below || illegal);

   io_lane_seq #(
      .SEQ_AW(AW), .LANE_W(LANE_W), .MAX_LANES(MAX_LANES)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .go(go), .base_in(base_fold),
      .nlanes_in(nl), .wr_in(wr), .wdata_in(wdata),
      .busy(busy), .lane_addr(lane_addr), .lane_first(first),
      .lane_last(last), .lane_wr(wr_q), .lane_wdata(lane_wdata)
   );

   io_region_map #(
      .MAP_AW(AW), .MAP_N(NREG), .ID_W(ID_W)
   ) u_map (
      .addr(lane_addr), .cfg_blk_err(cfg_blk_err),
      .cfg_void_clk(cfg_void_clk), .cls(cls), .id(id)
   );

   assign lane_byte = (cls == LC_REG) ? lane_rdata : '1;

   io_lane_acc #(
      .ID_W(ID_W), .LANE_W(LANE_W), .MAX_LANES(MAX_LANES)
   ) u_acc (
      .clk(clk), .rst_n(rst_n), .start(go), .nlanes_in(nl),
      .rej(rej), .rej_fault(below), .lane_act(busy),
      .lane_first(first), .lane_last(last), .cls(cls), .id(id),
      .lane_byte(lane_byte), .fresh(fresh), .rdata(rdata),
      .done(done), .bus_err(bus_err)
   );

   for (genvar i = 0; i < NREG; i++) begin : g_sel
      assign reg_sel[i] = busy && (cls == LC_REG) && fresh && (id == ID_W'(i));
   end

   assign lane_we = busy && wr_q && (cls == LC_REG);

endmodule

// File: rtl/io_sized_decoder_chk.sv
module io_sized_decoder_chk
   import io_dec_pkg::*;
(
   input logic            clk,
   input logic            rst_n,
   input logic            req,
   input logic            busy,
   input logic [AW-1:0]   a24,
   input logic [1:0]      size,
   input logic            done,
   input logic            bus_err,
   input logic [NREG-1:0] reg_sel,
   input logic            lane_we
);

   assert_err_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> done);

   assert_sel_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(reg_sel));

   assert_sel_only_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|reg_sel) |-> busy);

   assert_we_only_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
      lane_we |-> busy);

   assert_done_after_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   assert_below_faults_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !busy && (a24 < WIN_LO)) |=> (done && bus_err && !busy));

   assert_rsvd_size_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !busy && (a24 >= WIN_LO) && (size == 2'b11)) |=> (done && !bus_err && !busy));

endmodule

bind io_sized_decoder io_sized_decoder_chk u_chk (
   .clk(clk), .rst_n(rst_n), .req(req), .busy(busy), .a24(a24),
   .size(size), .done(done), .bus_err(bus_err), .reg_sel(reg_sel),
   .lane_we(lane_we)
);

// File: tb/sim_io_sized_decoder.sv
module sim_io_sized_decoder;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [31:0] addr = '0;
   logic [1:0]  size = '0;
   logic        wr = 1'b0;
   logic [31:0] wdata = '0;
   logic        cfg_blk_err = 1'b0;
   logic        cfg_void_clk = 1'b0;
   logic [7:0]  lane_rdata;
   logic [6:0]  reg_sel;
   logic [23:0] lane_addr;
   logic        lane_we;
   logic [7:0]  lane_wdata;
   logic [31:0] rdata;
   logic        done;
   logic        bus_err;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign lane_rdata = lane_addr[7:0] ^ 8'h5A;

   io_sized_decoder u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .size(size),
      .wr(wr), .wdata(wdata), .cfg_blk_err(cfg_blk_err),
      .cfg_void_clk(cfg_void_clk), .lane_rdata(lane_rdata),
      .reg_sel(reg_sel), .lane_addr(lane_addr), .lane_we(lane_we),
      .lane_wdata(lane_wdata), .rdata(rdata), .done(done), .bus_err(bus_err)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // 0..6 register index, 7 void, 8 bus error
   function automatic int ref_cls(input logic [23:0] a);
      if (cfg_void_clk && a >= 24'hFFFC21 && a <= 24'hFFFC3F) return 7;
      if (cfg_blk_err && a >= 24'hFF8A00 && a <= 24'hFF8A3F) return 8;
      if (a == 24'hFF8001) return 0;
      if (a == 24'hFF8205) return 1;
      if (a == 24'hFF8800 || a == 24'hFF8801) return 2;
      if (a == 24'hFF8802 || a == 24'hFF8803) return 3;
      if (a >= 24'hFF8A00 && a <= 24'hFF8A3F) return 4;
      if (a >= 24'hFFFA00 && a <= 24'hFFFA3F) return 5;
      if (a >= 24'hFFFC20 && a <= 24'hFFFC3F) return 6;
      return 8;
   endfunction

   task automatic access(input logic [31:0] a, input logic [1:0] sz, input logic w,
                         input logic [31:0] wd, input string tag, input bit poke);
      logic [23:0] b, la;
      logic [31:0] acc;
      logic [6:0]  esel;
      int n, c, prevc, ecnt;
      bit below, rej;
      b = a[23:0];
      n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : (sz == 2'b10) ? 4 : 0;
      below = (b < 24'hFF8000);
      rej = below || (n == 0) || (n == 2 && b > 24'hFFFFFE) || (n == 4 && b > 24'hFFFFFC);
      if (b >= 24'hFF8800 && b <= 24'hFF88FF) b = 24'hFF8800 + 24'(b[1:0]);
      req = 1'b1; addr = a; size = sz; wr = w; wdata = wd;
      @(negedge clk);
      req = 1'b0;
      if (rej) begin
         chk(done === 1'b1, tag, "reject done", 32'(done), 1);
         chk(bus_err === below, tag, "reject bus_err", 32'(bus_err), 32'(below));
         chk(rdata === 32'hFFFFFFFF, tag, "reject rdata", rdata, 32'hFFFFFFFF);
         chk(reg_sel === '0 && lane_we === 1'b0, tag, "reject lanes", {reg_sel, lane_we}, 0);
      end else begin
         ecnt = 0; acc = '0; prevc = -1;
         for (int k = 0; k < n; k++) begin
            la = b + 24'(k);
            c = ref_cls(la);
            chk(lane_addr === la, tag, "lane_addr", 32'(lane_addr), 32'(la));
            chk(done === 1'b0, tag, "done early", 32'(done), 0);
            esel = (c < 7 && c != prevc) ? 7'(1 << c) : 7'd0;
            chk(reg_sel === esel, tag, "reg_sel", 32'(reg_sel), 32'(esel));
            chk(lane_we === (w && c < 7), tag, "lane_we", 32'(lane_we), 32'(w && c < 7));
            if (w && c < 7)
               chk(lane_wdata === wd[8*(n-1-k) +: 8], tag, "lane_wdata", 32'(lane_wdata), 32'(wd[8*(n-1-k) +: 8]));
            if (c == 8) ecnt++;
            acc = {acc[23:0], (c < 7) ? (la[7:0] ^ 8'h5A) : 8'hFF};
            prevc = c;
            if (poke && k == 0) begin
               req = 1'b1; addr = 32'h00FF8001; size = 2'b00;
            end
            @(negedge clk);
            req = 1'b0;
         end
         chk(done === 1'b1, tag, "done", 32'(done), 1);
         chk(bus_err === (ecnt == n), tag, "bus_err", 32'(bus_err), 32'(ecnt == n));
         if (!w) chk(rdata === acc, tag, "rdata", rdata, acc);
         chk(reg_sel === '0 && lane_we === 1'b0, tag, "quiet at done", {reg_sel, lane_we}, 0);
      end
      @(negedge clk);
      chk(done === 1'b0 && bus_err === 1'b0, tag, "done pulse width", {done, bus_err}, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(done === 1'b0 && bus_err === 1'b0 && reg_sel === '0 && lane_we === 1'b0,
          "R2", "reset state", {done, bus_err, reg_sel, lane_we}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      access(32'h00FF8001, 2'b00, 1'b0, 0, "R12", 0);            // R12 byte read reg0
      access(32'h00FF8001, 2'b00, 1'b1, 32'h000000A7, "R12", 0); // R12 byte write
      access(32'h00FF8204, 2'b00, 1'b0, 0, "R3", 0);             // R3 byte fault
      access(32'h00FF8204, 2'b01, 1'b0, 0, "R3", 0);             // R3 word succeeds
      access(32'h00FF8204, 2'b00, 1'b1, 32'h55, "R4", 0);        // R4 error write
      access(32'h00FF8204, 2'b01, 1'b1, 32'hABCD, "R10", 0);     // R10 write lane order
      access(32'h00FF8800, 2'b10, 1'b1, 32'h11223344, "R5", 0);  // R5 two regs, once each
      access(32'h00FF88F5, 2'b10, 1'b0, 0, "R6", 0);             // R6 fold to FF8801
      access(32'h00FF8842, 2'b00, 1'b1, 32'h9C, "R6", 0);        // R6 fold to FF8802
      access(32'h00001000, 2'b01, 1'b0, 0, "R1", 0);             // R1 below window
      access(32'h12FF8001, 2'b00, 1'b0, 0, "R1", 0);             // R1 upper bits ignored
      access(32'h00FFFFFF, 2'b01, 1'b0, 0, "R8", 0);             // R8 word past top
      access(32'h00FFFFFD, 2'b10, 1'b1, 32'h1, "R8", 0);         // R8 long past top
      access(32'h00FF8001, 2'b11, 1'b0, 0, "R8", 0);             // R8 reserved size
      access(32'h00FFFFFC, 2'b10, 1'b0, 0, "R4", 0);             // R4 all-error long
      access(32'h00FFFA3E, 2'b01, 1'b0, 0, "R10", 0);            // R10 word read order
      access(32'h00FF8A10, 2'b00, 1'b0, 0, "R9", 0);             // R9 mapped when off
      cfg_blk_err = 1'b1;
      access(32'h00FF8A10, 2'b00, 1'b0, 0, "R9", 0);             // R9 error when on
      access(32'h00FF8A3E, 2'b10, 1'b0, 0, "R9", 0);             // R9 edge of range
      cfg_blk_err = 1'b0;
      access(32'h00FFFC24, 2'b10, 1'b1, 32'hDEADBEEF, "R7", 0);  // R7 mapped when off
      cfg_void_clk = 1'b1;
      access(32'h00FFFC20, 2'b10, 1'b0, 0, "R7", 0);             // R7 reg then void
      access(32'h00FFFC24, 2'b10, 1'b1, 32'hDEADBEEF, "R7", 0);  // R7 void ignores writes
      access(32'h00FFFC3E, 2'b10, 1'b0, 0, "R7", 0);             // R7 void + error, no fault
      cfg_void_clk = 1'b0;
      access(32'h00FF8802, 2'b10, 1'b0, 0, "R11", 1);            // R11 request while busy
      access(32'h00FF8001, 2'b00, 1'b0, 0, "R11", 1);            // R11 single-lane busy

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule